// File: doc/BRIEF.md
# Fractional-Increment Timebase Counter

This block keeps a free-running 64-bit timebase that advances at one fixed nominal rate, 6.144 MHz, whatever reference clock drives it. It does not divide by an integer. A rational increment does the work instead. On every reference clock a programmable numerator is added into a fractional accumulator. Whenever that sum reaches a programmable denominator, the denominator is taken away and the count steps by one. The mean count rate is therefore the reference frequency times numerator over denominator.

Software chooses the pair that suits the reference. Some examples:

| Reference | Pair |
|-----------|------|
| 38.4 MHz (the reset default) | 4/25 |
| 19.2 MHz | 8/25 |
| 12 MHz | 64/125 |
| 13 MHz | 768/1625 |
| 26 MHz | 384/1625 |
| 27 MHz | 256/1125 |

The count is never reloaded. It is visible whole on a parallel output for downstream timers. It can also be read as two 32-bit halves over a simple register port, and that read is coherent because reading the low half captures the high half.

Top module: `ftb_top`

## Requirements
- R1: After a synchronous active-low reset, `count_o` is 0, the accumulator is 0, the numerator word reads 4 and the denominator word reads 25.
- R2: On each clock with a nonzero denominator, the sum accumulator+numerator is formed. If the sum is at least the denominator, the count rises by exactly one, otherwise it holds. The count never rises by more than one per clock. Starting from a zero accumulator with numerator below denominator, the count after n clocks equals floor(n*num/den).
- R3: If the remainder left after subtracting the denominator is still at least the denominator, the accumulator is cleared. So a numerator at or above the denominator gives one increment on every clock, and the accumulator stays below the denominator.
- R4: A denominator of zero stops the counter: count and accumulator hold their values.
- R5: A write with `wr_en` high stores `wdata` into the numerator word at byte offset 0x10 or into the denominator word at offset 0x14. The fractional value is bits [11:0] of the word. The new value governs the step from the following clock on, and a write never clears the count.
- R6: Bits [31:12] of both configuration words are stored and read back exactly as written, and they have no effect on counting.
- R7: A read with `rd_en` high presents its data on `rdata` one clock later, and `rdata` holds until the next read. Offset 0x00 returns count[31:0] as it stood at the read edge and, on that same edge, captures count[63:32]. Offset 0x04 returns the captured high half.
- R8: A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the clock after `rd_en` |
| count_o | output | 64 | Free-running timebase count |

## Verification
The case that needs care is a configuration write that lands on the same edge as an accumulator wrap. The step on that edge must still use the old numerator and denominator, and the count must carry on without a clear. The bench provokes this by rewriting the pair while the counter is running, including cases where the new denominator is smaller than the accumulator's current value. It also reads the low count half on edges where the count steps, so that the captured high half and the returned low half both come from the same pre-edge value. A behavioural integer model updated at each rising edge judges every clock against `count_o` and against each read result.

// File: rtl/ftb_pkg.sv
`timescale 1ns/1ps
package ftb_pkg;
  localparam int unsigned FRAC_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 2 * DATA_W;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned NREG   = 2;

  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_NUM    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DEN    = 8'h14;

  typedef struct packed {
    logic [FRAC_W-1:0] acc;
    logic              tick;
  } step_t;

  // One reference-clock step of the rational accumulator.
  function automatic step_t frac_step(input logic [FRAC_W-1:0] acc,
                                      input logic [FRAC_W-1:0] num,
                                      input logic [FRAC_W-1:0] den);
    logic [FRAC_W:0] sum;
    logic [FRAC_W:0] rem;
    step_t r;
    sum    = {1'b0, acc} + {1'b0, num};
    rem    = sum - {1'b0, den};
    r.acc  = acc;
    r.tick = 1'b0;
    if (den != '0) begin
      if (sum >= {1'b0, den}) begin
        r.tick = 1'b1;
        r.acc  = (rem >= {1'b0, den}) ? '0 : rem[FRAC_W-1:0];
      end else begin
        r.acc  = sum[FRAC_W-1:0];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ftb_regs.sv
`timescale 1ns/1ps
module ftb_regs
  import ftb_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_NUM = 32'd4,
  parameter logic [DATA_W-1:0] RST_DEN = 32'd25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] num_word,
  output logic [DATA_W-1:0] den_word
);
  logic [DATA_W-1:0] word_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_cfg
    localparam logic [ADDR_W-1:0] OFS = (i == 0) ? OFS_NUM : OFS_DEN;
    localparam logic [DATA_W-1:0] RST = (i == 0) ? RST_NUM : RST_DEN;
    always_ff @(posedge clk) begin
      if (!rst_n)                      word_q[i] <= RST;
      else if (wr_en && (addr == OFS)) word_q[i] <= wdata;
    end
  end

  assign num_word = word_q[0];
  assign den_word = word_q[1];
endmodule

// File: rtl/ftb_accum.sv
`timescale 1ns/1ps
module ftb_accum
  import ftb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W-1:0] den,
  output logic [FRAC_W-1:0] acc_o,
  output logic              tick_o
);
  logic [FRAC_W-1:0] acc_q;
  step_t             nxt;

  always_comb nxt = frac_step(acc_q, num, den);

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= nxt.acc;
  end

  assign acc_o  = acc_q;
  assign tick_o = nxt.tick;
endmodule

// File: rtl/ftb_count.sv
`timescale 1ns/1ps
module ftb_count
  import ftb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              lo_read,
  output logic [CNT_W-1:0]  count_o,
  output logic [DATA_W-1:0] hi_shadow_o
);
  logic [CNT_W-1:0]  count_q;
  logic [DATA_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      hi_q    <= '0;
    end else begin
      count_q <= count_q + CNT_W'(tick);
      if (lo_read) hi_q <= count_q[CNT_W-1:DATA_W];
    end
  end

  assign count_o     = count_q;
  assign hi_shadow_o = hi_q;
endmodule

// File: rtl/ftb_top.sv
`timescale 1ns/1ps
module ftb_top
  import ftb_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_NUM = 32'd4,
  parameter logic [DATA_W-1:0] RST_DEN = 32'd25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] num_word, den_word, hi_shadow, rd_mux, rdata_q;
  logic [FRAC_W-1:0] num_frac, den_frac, acc;
  logic              tick, lo_read;

  ftb_regs #(.RST_NUM(RST_NUM), .RST_DEN(RST_DEN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .num_word(num_word), .den_word(den_word)
  );

  assign num_frac = num_word[FRAC_W-1:0];
  assign den_frac = den_word[FRAC_W-1:0];

  ftb_accum u_accum (
    .clk(clk), .rst_n(rst_n), .num(num_frac), .den(den_frac),
    .acc_o(acc), .tick_o(tick)
  );

  assign lo_read = rd_en && (addr == OFS_CNT_LO);

  ftb_count u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lo_read(lo_read),
    .count_o(count_o), .hi_shadow_o(hi_shadow)
  );

  always_comb begin
    case (addr)
      OFS_CNT_LO: rd_mux = count_o[DATA_W-1:0];
      OFS_CNT_HI: rd_mux = hi_shadow;
      OFS_NUM:    rd_mux = num_word;
      OFS_DEN:    rd_mux = den_word;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ftb_checker.sv
`timescale 1ns/1ps
module ftb_checker
  import ftb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              tick,
  input logic [FRAC_W-1:0] acc,
  input logic [FRAC_W-1:0] num_frac,
  input logic [FRAC_W-1:0] den_frac,
  input logic [CNT_W-1:0]  count_o
);
  AST_TICK_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count_o == $past(count_o) + 1'b1)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_o)); // R2
  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (den_frac != '0) |=> (acc < $past(den_frac))); // R3
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((den_frac != '0) && (num_frac >= den_frac)) |-> tick); // R3
  AST_ZERO_DEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (den_frac == '0) |=> ($stable(count_o) && $stable(acc))); // R4
  AST_NUM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == OFS_NUM)) |=> $stable(num_frac)); // R5
endmodule

bind ftb_top ftb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .tick(tick),
  .acc(acc), .num_frac(num_frac), .den_frac(den_frac), .count_o(count_o)
);

// File: tb/ftb_top_tb.sv
`timescale 1ns/1ps
module ftb_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] count_o;

  always #2 clk = ~clk;

  ftb_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .count_o(count_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit run_cmp = 1'b0;

  // behavioural reference state
  longint unsigned m_cnt;
  longint unsigned m_cyc;
  int unsigned     m_acc, m_hi, m_num, m_den, m_rd;

  task automatic chk(input string req, input longint unsigned got, input longint unsigned exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cyc = 0; m_acc = 0; m_hi = 0; m_rd = 0;
      m_num = 4; m_den = 25;
    end else begin
      int unsigned n, d, s;
      n = m_num % 4096;
      d = m_den % 4096;
      if (rd_en) begin
        if (addr == 8'h00) begin m_rd = int'(m_cnt % 64'h1_0000_0000); m_hi = int'(m_cnt >> 32); end
        else if (addr == 8'h04) m_rd = m_hi;
        else if (addr == 8'h10) m_rd = m_num;
        else if (addr == 8'h14) m_rd = m_den;
        else m_rd = 0;
      end
      if (d != 0) begin
        s = m_acc + n;
        if (s >= d) begin
          m_cnt++;
          s = (s - d >= d) ? 0 : s - d;
        end
        m_acc = s;
      end
      if (wr_en && addr == 8'h10) m_num = wdata;
      if (wr_en && addr == 8'h14) m_den = wdata;
      m_cyc++;
    end
  end

  always @(negedge clk) if (rst_n && run_cmp) chk("R2", count_o, m_cnt);

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    @(negedge clk); #1;
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    chk(req, rdata, m_rd);
    #1 rd_en = 1'b0;
  endtask

  task automatic rd_lit(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); #1;
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    chk(req, rdata, exp);
    #1 rd_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    longint unsigned c0;
    idle(5);
    chk("R1 count in reset", count_o, 0);
    @(negedge clk); #1 rst_n = 1'b1;
    run_cmp = 1'b1;
    rd_lit("R1 numerator", 8'h10, 32'd4);
    rd_lit("R1 denominator", 8'h14, 32'd25);
    idle(250);
    chk("R2 closed form 4/25", count_o, (m_cyc * 4) / 25);
    rd_chk("R7 low half", 8'h00);
    rd_chk("R7 high half", 8'h04);
    rd_lit("R8 unmapped", 8'h08, 32'd0);
    rd_lit("R8 unmapped", 8'h1c, 32'd0);

    c0 = count_o;
    wr(8'h10, 32'hABCDE008);
    chk("R5 no clear on write", count_o, m_cnt);
    if (count_o < c0) chk("R5 count dropped", count_o, c0);
    rd_lit("R6 upper bits kept", 8'h10, 32'hABCDE008);
    wr(8'h14, 32'h55555019);
    rd_lit("R6 upper bits kept", 8'h14, 32'h55555019);
    idle(300);
    chk("R6 upper bits inert", count_o, m_cnt);

    wr(8'h10, 32'd768); wr(8'h14, 32'd1625);
    idle(2000);
    wr(8'h10, 32'd64);  wr(8'h14, 32'd125);
    idle(500);
    wr(8'h10, 32'd384); wr(8'h14, 32'd1625);
    idle(800);
    wr(8'h10, 32'd256); wr(8'h14, 32'd1125);
    idle(800);
    rd_chk("R7 low half after run", 8'h00);
    rd_chk("R7 high half after run", 8'h04);

    wr(8'h14, 32'd0);
    c0 = count_o;
    idle(100);
    chk("R4 zero denominator holds", count_o, c0);

    wr(8'h10, 32'd100);
    wr(8'h14, 32'd30);
    c0 = count_o;
    idle(50);
    chk("R3 full rate num>den", count_o, c0 + 50);

    wr(8'h10, 32'd7); wr(8'h14, 32'd7);
    c0 = count_o;
    idle(40);
    chk("R3 full rate num=den", count_o, c0 + 40);

    wr(8'h10, 32'd3); wr(8'h14, 32'd40);
    idle(30);
    wr(8'h14, 32'd11);
    idle(60);
    for (int i = 0; i < 6; i++) begin
      rd_chk("R7 low read while ticking", 8'h00);
      rd_chk("R7 high read", 8'h04);
    end
    idle(20);
    finish_run();
  end
endmodule